// File: doc/BRIEF.md
# Clock Start-Up Gate with Fail-Safe Fallback

This block decides when the system clock may be handed to the core after system reset is released. Reset release alone does not mean the clock is usable: depending on the configured source, the block waits for the external oscillator to start toggling, for a start-up edge count to expire (crystal sources), and for the PLL to report lock (PLL sources). Until the chosen source is ready, the clock-valid output stays low and the core stays halted. Readiness tracking runs from the block's own reset, independently of any reset-release delay.

When fail-safe monitoring is enabled, it starts at the reset-release strobe. If the configured external source is not ready at that instant, the block selects the internal RC oscillator, raises a one-cycle trap request and sets a sticky failure flag. While running from the external source, the block watches for lost clock edges. If no edge arrives within a programmable number of reference cycles, it falls back in the same way. From the trap routine, software can ask to return to the external source. Every change of source is done glitch-free: clock-valid drops, the select changes only while it is low, and it stays low for a guard time on both sides of the change.

The block runs on the always-present internal reference clock. The external clock reaches it only as a sampled data input.

Top module: `clk_start_gate`

## Requirements
- R1: During and right after reset: `clk_valid_o`=0, `trap_o`=0, `clk_fail_o`=0, and `src_sel_o`=0. On `src_sel_o`, 0 means the internal RC oscillator and 1 means the external path.
- R2: With `mode_i`=2'b00 (internal RC), a release strobe gives `clk_valid_o`=1 with `src_sel_o`=0. This happens within 2*HOLD_CYC+2 cycles, and no trap is raised.
- R3: With `mode_i`=2'b01 (external clock input), the source is ready after the first sampled rising edge of `ext_clk_i`. The start-up edge count is not needed.
- R4: With `mode_i`=2'b10 (crystal), the source is not ready until OST_EDGES rising edges of `ext_clk_i` (default 1024) have been counted since reset.
- R5: With `mode_i`=2'b11 (crystal with PLL), the source additionally needs `pll_lock_i`. Without lock, `clk_valid_o` stays 0.
- R6: With `fscm_en_i`=0, a source that never becomes ready keeps `clk_valid_o`=0 indefinitely, and `trap_o` stays 0.
- R7: With `fscm_en_i`=1 and an external mode that is not ready at the release strobe, the block switches to `src_sel_o`=0, raises `trap_o` for exactly one cycle, and then asserts `clk_valid_o`.
- R8: `clk_fail_o` is set together with every trap and stays set until reset.
- R9: With `fscm_en_i`=1, while running on the external path, if no `ext_clk_i` edge arrives for `loss_limit_i` reference cycles, the block traps and falls back to `src_sel_o`=0. Readiness is then cleared.
- R10: While running on the internal RC in an external mode, `sw_req_i`=1 with the source ready returns to `src_sel_o`=1. `sw_req_i` has no effect while running on the external path.
- R11: `src_sel_o` changes only while `clk_valid_o` is low. `clk_valid_o` stays low for at least HOLD_CYC cycles before the change and at least HOLD_CYC cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rel_i | input | 1 | One-cycle system reset release strobe |
| ext_clk_i | input | 1 | External oscillator, sampled as data |
| pll_lock_i | input | 1 | PLL lock indication (asynchronous) |
| mode_i | input | 2 | Source configuration: 00 RC, 01 external clock, 10 crystal, 11 crystal+PLL |
| fscm_en_i | input | 1 | Fail-safe monitoring enable |
| sw_req_i | input | 1 | Software request to return to the external path |
| loss_limit_i | input | LOSS_W | Reference cycles without an edge that count as clock loss |
| src_sel_o | output | 1 | Selected source: 0 RC, 1 external |
| clk_valid_o | output | 1 | Clock released to the core |
| trap_o | output | 1 | One-cycle trap request |
| clk_fail_o | output | 1 | Sticky clock failure flag |

## Verification
Two events can land in the same cycle: a clock-loss detection and a software request to return to the external path. The bench holds `sw_req_i` high across the moment the external clock stops. The result is judged correct if exactly one trap fires and the select falls to the RC source. The select must then stay there while the request is still held, because the request only acts on the RC path and readiness was cleared by the loss.

// File: rtl/clk_start_pkg.sv
// Shared types for the clock start-up gate: mode codes and controller states.
package clk_start_pkg;
    typedef enum logic [1:0] {
        MODE_RC   = 2'b00,
        MODE_EXT  = 2'b01,
        MODE_XTAL = 2'b10,
        MODE_XPLL = 2'b11
    } src_mode_e;

    typedef enum logic [2:0] {
        ST_WAIT_REL,
        ST_WAIT_RDY,
        ST_HOLD_PRE,
        ST_HOLD_POST,
        ST_RUN
    } gate_state_e;
endpackage

// File: rtl/clk_ready_track.sv
// Tracks the readiness of the external source on the reference clock.
// It synchronises the external clock and the PLL lock, detects rising
// edges, notes the first edge, and counts edges up to OST_EDGES.
// Assumes the external clock is slower than half the reference clock.
module clk_ready_track
    import clk_start_pkg::*;
#(
    parameter int OST_EDGES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       ext_clk_i,
    input  logic       pll_lock_i,
    input  logic [1:0] mode_i,
    output logic       edge_o,
    output logic       ready_o
);
    localparam int CW = $clog2(OST_EDGES + 1);

    logic [2:0]    ext_sync;
    logic [1:0]    lock_sync;
    logic          started;
    logic [CW-1:0] ost_cnt;
    logic          ost_done;

    // Three-stage sampler: two stages for metastability, one for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync  <= '0;
            lock_sync <= '0;
        end else begin
            ext_sync  <= {ext_sync[1:0], ext_clk_i};
            lock_sync <= {lock_sync[0], pll_lock_i};
        end
    end

    assign edge_o   = ext_sync[1] & ~ext_sync[2];
    assign ost_done = (ost_cnt == CW'(OST_EDGES));

    // Start detection and saturating start-up edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            started <= 1'b0;
            ost_cnt <= '0;
        end else if (edge_o) begin
            started <= 1'b1;
            if (!ost_done) ost_cnt <= ost_cnt + 1'b1;
        end
    end

    // Per-mode readiness.
    always_comb begin
        unique case (src_mode_e'(mode_i))
            MODE_RC:   ready_o = 1'b1;
            MODE_EXT:  ready_o = started;
            MODE_XTAL: ready_o = ost_done;
            default:   ready_o = ost_done & lock_sync[1];
        endcase
    end
endmodule

// File: rtl/clk_edge_watchdog.sv
// Counts reference cycles since the last external edge while enabled.
// Flags loss when the count reaches the limit. A limit of zero flags at once.
module clk_edge_watchdog #(
    parameter int LOSS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              edge_i,
    input  logic [LOSS_W-1:0] limit_i,
    output logic              loss_o
);
    logic [LOSS_W-1:0] gap_cnt;

    // Gap counter: cleared by an edge or when disabled, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || edge_i) gap_cnt <= '0;
        else if (gap_cnt != limit_i)   gap_cnt <= gap_cnt + 1'b1;
    end

    assign loss_o = en_i & (gap_cnt == limit_i);
endmodule

// File: rtl/clk_switch_ctrl.sv
// Sequences release, fallback and return. Every change of source is
// bracketed by HOLD_CYC cycles with clock-valid low on each side.
// Assumes HOLD_CYC reference cycles cover one period of the external clock.
module clk_switch_ctrl
    import clk_start_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rel_i,
    input  logic [1:0] mode_i,
    input  logic       fscm_en_i,
    input  logic       sw_req_i,
    input  logic       ready_i,
    input  logic       loss_i,
    output logic       sel_o,
    output logic       valid_o,
    output logic       trap_o,
    output logic       fail_o,
    output logic       clr_o,
    output logic       mon_en_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    gate_state_e   state;
    logic          tgt;
    logic [HW-1:0] hold_cnt;
    logic          rc_mode;

    assign rc_mode = (src_mode_e'(mode_i) == MODE_RC);

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT_REL;
            sel_o    <= 1'b0;
            tgt      <= 1'b0;
            hold_cnt <= '0;
            trap_o   <= 1'b0;
            fail_o   <= 1'b0;
            clr_o    <= 1'b0;
        end else begin
            trap_o <= 1'b0;
            clr_o  <= 1'b0;
            unique case (state)
                ST_WAIT_REL: if (rel_i) begin
                    hold_cnt <= '0;
                    if (rc_mode) begin
                        tgt   <= 1'b0;
                        state <= ST_HOLD_PRE;
                    end else if (ready_i) begin
                        tgt   <= 1'b1;
                        state <= ST_HOLD_PRE;
                    end else if (fscm_en_i) begin
                        tgt    <= 1'b0;
                        trap_o <= 1'b1;
                        fail_o <= 1'b1;
                        state  <= ST_HOLD_PRE;
                    end else begin
                        state <= ST_WAIT_RDY;
                    end
                end
                ST_WAIT_RDY: if (ready_i) begin
                    tgt      <= 1'b1;
                    hold_cnt <= '0;
                    state    <= ST_HOLD_PRE;
                end
                ST_HOLD_PRE: begin
                    if (hold_cnt == HW'(HOLD_CYC - 1)) begin
                        sel_o    <= tgt;
                        hold_cnt <= '0;
                        state    <= ST_HOLD_POST;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                ST_HOLD_POST: begin
                    if (hold_cnt == HW'(HOLD_CYC - 1)) begin
                        hold_cnt <= '0;
                        state    <= ST_RUN;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: begin
                    if (sel_o && loss_i) begin
                        tgt      <= 1'b0;
                        trap_o   <= 1'b1;
                        fail_o   <= 1'b1;
                        clr_o    <= 1'b1;
                        hold_cnt <= '0;
                        state    <= ST_HOLD_PRE;
                    end else if (!sel_o && !rc_mode && sw_req_i && ready_i) begin
                        tgt      <= 1'b1;
                        hold_cnt <= '0;
                        state    <= ST_HOLD_PRE;
                    end
                end
            endcase
        end
    end

    assign valid_o  = (state == ST_RUN);
    assign mon_en_o = fscm_en_i & valid_o & sel_o;
endmodule

// File: rtl/clk_start_gate.sv
// Top level: readiness tracker, edge-loss watchdog and switch sequencer.
// Runs entirely on the internal reference clock; the external clock is data.
module clk_start_gate #(
    parameter int OST_EDGES = 1024,
    parameter int LOSS_W    = 16,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_i,
    input  logic              ext_clk_i,
    input  logic              pll_lock_i,
    input  logic [1:0]        mode_i,
    input  logic              fscm_en_i,
    input  logic              sw_req_i,
    input  logic [LOSS_W-1:0] loss_limit_i,
    output logic              src_sel_o,
    output logic              clk_valid_o,
    output logic              trap_o,
    output logic              clk_fail_o
);
    logic ext_edge, src_ready, loss, clr, mon_en;

    clk_ready_track #(.OST_EDGES(OST_EDGES)) u_track (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .ext_clk_i(ext_clk_i),
        .pll_lock_i(pll_lock_i), .mode_i(mode_i),
        .edge_o(ext_edge), .ready_o(src_ready)
    );

    clk_edge_watchdog #(.LOSS_W(LOSS_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .en_i(mon_en), .edge_i(ext_edge),
        .limit_i(loss_limit_i), .loss_o(loss)
    );

    clk_switch_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rel_i(rel_i), .mode_i(mode_i),
        .fscm_en_i(fscm_en_i), .sw_req_i(sw_req_i), .ready_i(src_ready),
        .loss_i(loss), .sel_o(src_sel_o), .valid_o(clk_valid_o),
        .trap_o(trap_o), .fail_o(clk_fail_o), .clr_o(clr), .mon_en_o(mon_en)
    );
endmodule

// File: rtl/clk_start_gate_chk.sv
// Property checker for clk_start_gate, attached by bind.
module clk_start_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       fscm_en_i,
    input logic       src_sel_o,
    input logic       clk_valid_o,
    input logic       trap_o,
    input logic       clk_fail_o
);
    p_trap_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);
    p_trap_sets_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> clk_fail_o);
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fail_o |=> clk_fail_o);
    p_sel_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel_o) |-> (!clk_valid_o && !$past(clk_valid_o)));
    p_trap_needs_monitor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(fscm_en_i));
    p_rc_mode_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_valid_o && mode_i == 2'b00) |-> !src_sel_o);
endmodule

bind clk_start_gate clk_start_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fscm_en_i(fscm_en_i),
    .src_sel_o(src_sel_o), .clk_valid_o(clk_valid_o), .trap_o(trap_o),
    .clk_fail_o(clk_fail_o)
);

// File: tb/clk_start_gate_tb.sv
module clk_start_gate_tb;
    localparam int HOLD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rel = 1'b0;
    logic        ext_clk = 1'b0;
    logic        ext_run = 1'b0;
    logic        lock = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        fscm = 1'b0;
    logic        sw_req = 1'b0;
    logic [15:0] limit = 16'd40;
    logic        sel, valid, trap, fail;

    int checks = 0;
    int errors = 0;
    int trap_total = 0;
    int trap_run = 0;
    int trap_max = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always begin
        #80;
        if (ext_run) ext_clk = ~ext_clk;
    end

    clk_start_gate u_dut (
        .clk(clk), .rst_n(rst_n), .rel_i(rel), .ext_clk_i(ext_clk),
        .pll_lock_i(lock), .mode_i(mode), .fscm_en_i(fscm), .sw_req_i(sw_req),
        .loss_limit_i(limit), .src_sel_o(sel), .clk_valid_o(valid),
        .trap_o(trap), .clk_fail_o(fail)
    );

    // Trap monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (trap) begin
            trap_total = trap_total + 1;
            trap_run   = trap_run + 1;
            if (trap_run > trap_max) trap_max = trap_run;
        end else begin
            trap_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rel = 1'b0; sw_req = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_rel();
        rel = 1'b1;
        @(negedge clk);
        rel = 1'b0;
    endtask

    // Waits up to n cycles for valid; returns the number waited, or -1.
    task automatic wait_valid(input int n, output int took);
        took = -1;
        for (int i = 0; i < n; i++) begin
            if (valid) begin took = i; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        ext_run = 1'b0; mode = 2'b10; fscm = 1'b1;
        do_reset();
        chk(!valid, "R1", "valid after reset", valid, 0);
        chk(!trap, "R1", "trap after reset", trap, 0);
        chk(!fail, "R1", "fail after reset", fail, 0);
        chk(!sel, "R1", "sel after reset", sel, 0);
    endtask

    task automatic t_rc_mode();
        int took, t0;
        ext_run = 1'b0; mode = 2'b00; fscm = 1'b1;
        do_reset();
        t0 = trap_total;
        pulse_rel();
        wait_valid(2*HOLD + 2, took);
        chk(took >= 0, "R2", "rc valid in time", took, 2*HOLD);
        chk(!sel, "R2", "rc select", sel, 0);
        chk(trap_total == t0, "R2", "rc no trap", trap_total - t0, 0);
    endtask

    task automatic t_ext_mode();
        int took;
        ext_run = 1'b1; mode = 2'b01; fscm = 1'b0;
        do_reset();
        repeat (50) @(negedge clk);
        pulse_rel();
        wait_valid(20, took);
        chk(took >= 0, "R3", "external valid after few edges", took, 10);
        chk(sel, "R3", "external select", sel, 1);
    endtask

    task automatic t_xtal_mode();
        int took;
        ext_run = 1'b1; mode = 2'b10; fscm = 1'b0;
        do_reset();
        pulse_rel();
        repeat (7900) @(negedge clk);
        chk(!valid, "R4", "held before start-up count", valid, 0);
        wait_valid(2000, took);
        chk(took >= 0, "R4", "valid after start-up count", took, 300);
        chk(sel, "R4", "crystal select", sel, 1);
        ext_run = 1'b0;
    endtask

    task automatic t_pll_mode();
        int took;
        ext_run = 1'b1; mode = 2'b11; fscm = 1'b0; lock = 1'b0;
        do_reset();
        repeat (9000) @(negedge clk);
        pulse_rel();
        repeat (300) @(negedge clk);
        chk(!valid, "R5", "held without lock", valid, 0);
        lock = 1'b1;
        wait_valid(20, took);
        chk(took >= 0, "R5", "valid after lock", took, 8);
        lock = 1'b0;
        ext_run = 1'b0;
    endtask

    task automatic t_dead_no_monitor();
        int t0;
        ext_run = 1'b0; mode = 2'b10; fscm = 1'b0;
        do_reset();
        t0 = trap_total;
        pulse_rel();
        repeat (2000) @(negedge clk);
        chk(!valid, "R6", "dead source keeps core held", valid, 0);
        chk(trap_total == t0, "R6", "no trap without monitor", trap_total - t0, 0);
    endtask

    // Fallback at release, return by software, loss, and loss coinciding
    // with a held return request.
    task automatic t_failsafe();
        int took, t0, pre, post;
        bit seen_change;
        ext_run = 1'b1; mode = 2'b10; fscm = 1'b1;
        do_reset();
        t0 = trap_total;
        trap_max = 0;
        pulse_rel();
        wait_valid(20, took);
        chk(took >= 0, "R7", "valid on fallback", took, 2*HOLD);
        chk(!sel, "R7", "fallback select", sel, 0);
        chk(trap_total - t0 == 1 && trap_max == 1, "R7", "single one-cycle trap",
            trap_total - t0, 1);
        chk(fail, "R8", "fail set with trap", fail, 1);

        repeat (9000) @(negedge clk);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        repeat (2*HOLD + 3) @(negedge clk);
        chk(sel && valid, "R10", "return to external", sel, 1);
        chk(fail, "R8", "fail sticky after return", fail, 1);

        // Loss while a return request is held.
        t0 = trap_total;
        sw_req = 1'b1;
        ext_run = 1'b0;
        pre = 0; post = 0; seen_change = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!valid && !seen_change && sel) pre++;
            if (!sel) seen_change = 1'b1;
            if (!valid && seen_change) post++;
            if (valid && seen_change) break;
        end
        chk(trap_total - t0 == 1, "R9", "trap on clock loss", trap_total - t0, 1);
        chk(!sel && valid, "R9", "running on RC after loss", sel, 0);
        chk(pre >= HOLD, "R11", "valid low before select change", pre, HOLD);
        chk(post >= HOLD, "R11", "valid low after select change", post, HOLD);
        repeat (500) @(negedge clk);
        chk(!sel, "R10", "held request ignored after loss", sel, 0);
        chk(trap_total - t0 == 1, "R9", "no extra trap", trap_total - t0, 1);
        sw_req = 1'b0;
        do_reset();
        chk(!fail, "R8", "fail cleared by reset", fail, 1'b0);
    endtask

    initial begin
        t_reset();
        t_rc_mode();
        t_ext_mode();
        t_xtal_mode();
        t_pll_mode();
        t_dead_no_monitor();
        t_failsafe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule